// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block is a word-wide storage array with two fully independent ports, each running on its own clock. The write port stores one word per enabled write-clock edge at the address held by its own counter and then steps that counter. The read port fetches one word per enabled read-clock edge from the address held by a second counter, presents it on a registered output, and steps its counter. The read bus is released to high impedance whenever reading is disabled.

There is no occupancy tracking of any kind: no full flag, no empty flag, and the two counters are never compared. A user delays a video line, or any stream with a known period, by clearing the write counter at the start of a line and clearing the read counter some time later. The distance between the two clears sets the delay. Each counter has its own synchronous active-low clear, and that clear takes priority over the port's enable. Both counters wrap from the last word back to word zero.

Top module: `line_delay_mem`

## Requirements
- R1: On a write-clock rising edge with `wr_en_n` low, `wr_data` is stored at the current write address, and the write counter advances by one on the same edge.
- R2: On a write-clock rising edge with `wr_en_n` high, nothing is stored and the write counter keeps its value. Data presented during such an edge is never read back.
- R3: On a write-clock rising edge with `wr_clr_n` low, the write counter becomes 0. If `wr_en_n` is also low, the word is still stored at the pre-clear address. The next enabled write then lands at address 0.
- R4: On a read-clock rising edge with `rd_en_n` low, the word at the current read address is registered onto `rd_data`, `rd_drive` becomes 1 just after that edge, and the read counter advances by one.
- R5: On a read-clock rising edge with `rd_en_n` high, the read counter keeps its value and `rd_drive` becomes 0 just after that edge. While `rd_drive` is 0, `rd_data` is high impedance. The next enabled read returns the word after the last one read.
- R6: On a read-clock rising edge with `rd_clr_n` low, the read counter becomes 0. If `rd_en_n` is also low, the word at the pre-clear address is still output. The next enabled read returns the word at address 0.
- R7: Each counter wraps from address DEPTH-1 to address 0 when it advances.
- R8: The two ports use unrelated clocks. Data written through one port is read back in write order through the other port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_clr_n | input | 1 | Synchronous write counter clear, active low |
| wr_data | input | DW | Word to store |
| rd_clk | input | 1 | Read port clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_clr_n | input | 1 | Synchronous read counter clear, active low |
| rd_data | output | DW | Registered read word; high impedance when not driven |
| rd_drive | output | 1 | 1 while `rd_data` is actively driven |

## Verification
Every read result is due just after the read-clock edge that sampled the read controls: one register stage, with no further latency. The bench drives each read operation at a falling read-clock edge and queues the expected `rd_drive` and word at that moment. A monitor pops one entry 2 ns after the next rising read-clock edge, so each comparison lands in the cycle where the registered output has just changed. Write-side effects show up only through later reads. For that reason, writes and the reads that check them are kept in separate phases, and an independent address model predicts every word.

// File: rtl/line_delay_mem.sv
module line_delay_mem #(
  parameter int DW    = 10,
  parameter int DEPTH = 1024
) (
  input  logic          wr_clk,
  input  logic          wr_en_n,
  input  logic          wr_clr_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_en_n,
  input  logic          rd_clr_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] rd_q;
  logic          rd_oe = 1'b0;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge wr_clk) begin
    if (!wr_en_n) mem[wr_ptr] <= wr_data;
    if (!wr_clr_n)     wr_ptr <= '0;
    else if (!wr_en_n) wr_ptr <= step(wr_ptr);
  end

  always_ff @(posedge rd_clk) begin
    if (!rd_en_n) rd_q <= mem[rd_ptr];
    rd_oe <= !rd_en_n;
    if (!rd_clr_n)     rd_ptr <= '0;
    else if (!rd_en_n) rd_ptr <= step(rd_ptr);
  end

  assign rd_drive = rd_oe;
  assign rd_data  = rd_oe ? rd_q : {DW{1'bz}};

  logic wr_known = 1'b0;
  logic rd_known = 1'b0;
  always_ff @(posedge wr_clk) if (!wr_clr_n) wr_known <= 1'b1;
  always_ff @(posedge rd_clk) if (!rd_clr_n) rd_known <= 1'b1;

  // R1
  wr_advance_chk: assert property (@(posedge wr_clk) disable iff (!wr_known)
    (wr_clr_n && !wr_en_n && wr_ptr != LAST) |=> wr_ptr == $past(wr_ptr) + 1'b1);
  // R2
  wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_known)
    (wr_clr_n && wr_en_n) |=> $stable(wr_ptr));
  // R3
  wr_clear_chk: assert property (@(posedge wr_clk) disable iff (!wr_known)
    !wr_clr_n |=> wr_ptr == '0);
  // R7
  wr_wrap_chk: assert property (@(posedge wr_clk) disable iff (!wr_known)
    (wr_clr_n && !wr_en_n && wr_ptr == LAST) |=> wr_ptr == '0);
  // R4
  rd_drive_on_chk: assert property (@(posedge rd_clk) disable iff (!rd_known)
    !rd_en_n |=> rd_drive);
  // R5
  rd_release_chk: assert property (@(posedge rd_clk) disable iff (!rd_known)
    rd_en_n |=> !rd_drive);
  // R5
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_known)
    (rd_clr_n && rd_en_n) |=> $stable(rd_ptr));
  // R6
  rd_clear_chk: assert property (@(posedge rd_clk) disable iff (!rd_known)
    !rd_clr_n |=> rd_ptr == '0);
  // R7
  rd_wrap_chk: assert property (@(posedge rd_clk) disable iff (!rd_known)
    (rd_clr_n && !rd_en_n && rd_ptr == LAST) |=> rd_ptr == '0);
endmodule

// File: tb/line_delay_mem_test.sv
`timescale 1ns/1ps
module line_delay_mem_test;
  localparam int DW = 10;
  localparam int DEPTH = 32;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_en_n = 1, wr_clr_n = 1, rd_en_n = 1, rd_clr_n = 1;
  logic [DW-1:0] wr_data = '0;
  wire  [DW-1:0] rd_data;
  wire           rd_drive;

  always #4   wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  line_delay_mem #(.DW(DW), .DEPTH(DEPTH)) uut (
    .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_clr_n(wr_clr_n), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_clr_n(rd_clr_n),
    .rd_data(rd_data), .rd_drive(rd_drive));

  typedef struct {
    logic          drv;
    logic [DW-1:0] dat;
    string         req;
  } exp_t;

  exp_t expq[$];
  logic [DW-1:0] mdl [DEPTH];
  int wp = 0, rp = 0;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic wr_op(input logic en_n, input logic clr_n, input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en_n = en_n; wr_clr_n = clr_n; wr_data = d;
    if (!en_n) mdl[wp] = d;
    if (!clr_n) wp = 0;
    else if (!en_n) wp = (wp + 1) % DEPTH;
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_en_n = 1; wr_clr_n = 1;
  endtask

  task automatic rd_op(input logic en_n, input logic clr_n, input string req);
    exp_t e;
    @(negedge rd_clk);
    rd_en_n = en_n; rd_clr_n = clr_n;
    e.drv = !en_n;
    e.dat = en_n ? '0 : mdl[rp];
    e.req = req;
    expq.push_back(e);
    if (!clr_n) rp = 0;
    else if (!en_n) rp = (rp + 1) % DEPTH;
  endtask

  task automatic rd_idle();
    @(negedge rd_clk);
    rd_en_n = 1; rd_clr_n = 1;
  endtask

  initial begin
    forever begin
      @(posedge rd_clk);
      #2;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        total++;
        if (rd_drive !== e.drv) begin
          bad++;
          $display("FAIL %s: rd_drive=%b expected %b", e.req, rd_drive, e.drv);
        end else if (e.drv && rd_data !== e.dat) begin
          bad++;
          $display("FAIL %s: rd_data=%h expected %h", e.req, rd_data, e.dat);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge wr_clk);
    // R3: clear only, then R1 line of 10 words
    wr_op(1, 0, '0);
    for (int i = 0; i < 10; i++) wr_op(0, 1, DW'(10'h100 + i));
    // R2: gap with data that must never appear
    wr_op(1, 1, 10'h3FF);
    wr_op(1, 1, 10'h3FE);
    wr_op(0, 1, 10'h10A);
    wr_op(0, 1, 10'h10B);
    wr_idle();

    // R5 reset-state style: clear with enable high gives released bus
    rd_op(1, 0, "R5");
    for (int i = 0; i < 6; i++) rd_op(0, 1, "R8");
    rd_op(1, 1, "R5");
    rd_op(1, 1, "R5");
    for (int i = 0; i < 6; i++) rd_op(0, 1, "R2");
    rd_idle();
    wait (expq.size() == 0);

    // R3: clear together with write stores at pre-clear address (12)
    wr_op(0, 0, 10'h2AA);
    for (int i = 0; i < 3; i++) wr_op(0, 1, DW'(10'h050 + i));
    wr_idle();
    rd_op(1, 0, "R5");
    for (int i = 0; i < 3; i++) rd_op(0, 1, "R3");
    for (int i = 0; i < 9; i++) rd_op(0, 1, "R4");
    // R6: clear with read outputs pre-clear word (0x2AA at 12), next read at 0
    rd_op(0, 0, "R6");
    rd_op(0, 1, "R6");
    rd_idle();
    wait (expq.size() == 0);

    // R7: wrap on both counters
    wr_op(1, 0, '0);
    for (int i = 0; i < DEPTH + 3; i++) wr_op(0, 1, DW'(10'h200 + i));
    wr_idle();
    rd_op(1, 0, "R5");
    for (int i = 0; i < DEPTH + 3; i++) rd_op(0, 1, "R7");
    rd_op(1, 1, "R5");
    rd_idle();
    wait (expq.size() == 0);
    repeat (2) @(posedge rd_clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule